// File: doc/BRIEF.md
# Two-Client Bus Cycle Arbiter

This block sits between two internal bus clients and a single 32-bit external memory and I/O bus. One client is the instruction fetcher, which reads code. The other is the execution pipeline, which moves operands. Each client presents a request together with an address, byte enables, a write flag and write data. The arbiter picks one client when the bus is free and runs exactly one external bus cycle for it. It returns read data and a one-clock completion pulse to that client.

Operand transfers always come first. The fetcher gets the bus only on an idle cycle in which the execution client is not asking for it. A cycle that has started is never abandoned. The address and controls stay on the bus until the external side signals ready. The bidirectional data bus appears as separate in and out vectors plus an output enable, which is raised only while a write is on the bus.

A client holds its request until it sees its done pulse. It drops the request in that done cycle unless it wants another transfer straight away.

Top module: `bus_prio_arb`

## Requirements
- R1: While reset is high and in the first cycle after it, `bus_stb`, `bus_doe`, both grants and both done outputs are 0, `bus_be` is 0 and `rd_data` is 0.
- R2: When the bus is idle and `dat_req` is 1, the next cycle starts a cycle for the execution client (`dat_gnt`=1, `fch_gnt`=0), whatever `fch_req` is.
- R3: When the bus is idle, `fch_req` is 1 and `dat_req` is 0, the next cycle starts a fetch cycle (`fch_gnt`=1).
- R4: A started cycle is not pre-empted. The grant, `bus_addr`, `bus_be`, `bus_wr` and `bus_dout` stay constant until the clock edge at which `bus_rdy` is sampled high, even if the other client requests meanwhile.
- R5: The cycle presents the address, byte enables, write flag and write data that the winning client drove at the edge where it was chosen. `bus_stb` is 1 from the next cycle on.
- R6: The cycle ends at the first edge with `bus_stb`=1 and `bus_rdy`=1. `bus_stb` is 0 in the following cycle.
- R7: `bus_doe` is 1 exactly while `bus_stb` and `bus_wr` are both 1. `bus_wr` and `bus_be` read 0 while idle.
- R8: At the ending edge of a read cycle, `rd_data` takes the value of `bus_din`. It keeps that value through write cycles and idle time until the next read ends.
- R9: In the cycle after the ending edge, the owning client's done output is 1 for exactly one clock. The other client's done output stays 0.
- R10: A grant is 1 only for the owner of an active cycle, and the two grants are never 1 together.
- R11: Between two bus cycles there is exactly one cycle with `bus_stb`=0 when a request is already waiting. That cycle is the done cycle.
- R12: `bus_rdy` has no effect while `bus_stb` is 0. It produces no done pulse and does not change `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fch_req | input | 1 | Fetcher requests a bus cycle |
| fch_addr | input | 32 | Fetcher address |
| fch_be | input | 4 | Fetcher byte enables |
| fch_wr | input | 1 | Fetcher write flag |
| fch_wdata | input | 32 | Fetcher write data |
| fch_gnt | output | 1 | Fetcher owns the active cycle |
| fch_done | output | 1 | Fetcher cycle complete, one clock |
| dat_req | input | 1 | Execution client requests a bus cycle |
| dat_addr | input | 32 | Execution client address |
| dat_be | input | 4 | Execution client byte enables |
| dat_wr | input | 1 | Execution client write flag |
| dat_wdata | input | 32 | Execution client write data |
| dat_gnt | output | 1 | Execution client owns the active cycle |
| dat_done | output | 1 | Execution client cycle complete, one clock |
| rd_data | output | 32 | Data captured by the last read |
| bus_addr | output | 32 | External address |
| bus_be | output | 4 | External byte enables |
| bus_wr | output | 1 | External direction, 1 = write |
| bus_stb | output | 1 | External cycle active |
| bus_rdy | input | 1 | External ready, ends the cycle |
| bus_din | input | 32 | External data bus, inbound |
| bus_dout | output | 32 | External data bus, outbound |
| bus_doe | output | 1 | Outbound data enable |

## Verification
The bench drives both clients at once from an idle bus. A design that honoured arrival order, or favoured the fetcher, would grant the wrong client. It raises the execution request partway through a fetch held by wait states. A pre-empting design would drop the fetch grant or move the address before ready.

It holds requests through the done cycle to test back-to-back cycles. A design without the idle slot would keep `bus_stb` high, and a slow one would leave a gap longer than one clock. It pulses ready while idle and mixes writes between reads. A design that captured `bus_din` on writes, or took stray ready pulses, would corrupt `rd_data` or emit an unowned done pulse.

// File: rtl/bpa_pkg.sv
package bpa_pkg;

   typedef enum logic [0:0] {
      OWN_FCH = 1'b0,
      OWN_DAT = 1'b1
   } bpa_owner_e;

   typedef enum logic [0:0] {
      PH_IDLE = 1'b0,
      PH_BUSY = 1'b1
   } bpa_phase_e;

   function automatic int unsigned bpa_lanes(input int unsigned data_w);
      return data_w / 8;
   endfunction

endpackage

// File: rtl/bpa_pick.sv
module bpa_pick
   import bpa_pkg::*;
#(
   parameter bit DATA_FIRST = 1'b1
) (
   input  logic       idle,
   input  logic       fch_req,
   input  logic       dat_req,
   output logic       start,
   output bpa_owner_e pick
);

   logic any_req;

   assign any_req = fch_req | dat_req;
   assign start   = idle & any_req;

   generate
      if (DATA_FIRST) begin : g_data_first
         always_comb begin
            if (dat_req) pick = OWN_DAT;
            else         pick = OWN_FCH;
         end
      end else begin : g_fetch_first
         always_comb begin
            if (fch_req) pick = OWN_FCH;
            else         pick = OWN_DAT;
         end
      end
   endgenerate

endmodule

// File: rtl/bpa_seq.sv
module bpa_seq
   import bpa_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  bpa_owner_e pick,
   input  logic       rdy,
   output logic       busy,
   output bpa_owner_e owner,
   output logic       finish,
   output logic       fch_done,
   output logic       dat_done
);

   bpa_phase_e phase_q;
   bpa_owner_e owner_q;
   logic       fch_done_q;
   logic       dat_done_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q    <= PH_IDLE;
         owner_q    <= OWN_FCH;
         fch_done_q <= 1'b0;
         dat_done_q <= 1'b0;
      end else begin
         fch_done_q <= 1'b0;
         dat_done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (start) begin
                  phase_q <= PH_BUSY;
                  owner_q <= pick;
               end
            end
            PH_BUSY: begin
               if (rdy) begin
                  phase_q    <= PH_IDLE;
                  fch_done_q <= (owner_q == OWN_FCH);
                  dat_done_q <= (owner_q == OWN_DAT);
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign busy     = (phase_q == PH_BUSY);
   assign owner    = owner_q;
   assign finish   = busy & rdy;
   assign fch_done = fch_done_q;
   assign dat_done = dat_done_q;

endmodule

// File: rtl/bpa_hold.sv
module bpa_hold
   import bpa_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned DATA_W         = 32,
   parameter bit          IDLE_ADDR_ZERO = 1'b0,
   parameter bit          LANE_MASKED    = 1'b0,
   localparam int unsigned BE_W          = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  bpa_owner_e        pick,
   input  logic              busy,
   input  logic              finish,
   input  logic [ADDR_W-1:0] fch_addr,
   input  logic [BE_W-1:0]   fch_be,
   input  logic              fch_wr,
   input  logic [DATA_W-1:0] fch_wdata,
   input  logic [ADDR_W-1:0] dat_addr,
   input  logic [BE_W-1:0]   dat_be,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   input  logic [DATA_W-1:0] bus_din,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BE_W-1:0]   bus_be,
   output logic              bus_wr,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe,
   output logic [DATA_W-1:0] rd_data
);

   logic [ADDR_W-1:0] sel_addr;
   logic [BE_W-1:0]   sel_be;
   logic              sel_wr;
   logic [DATA_W-1:0] sel_wdata;

   logic [ADDR_W-1:0] addr_q;
   logic [BE_W-1:0]   be_q;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdat_q;
   logic              rd_end;

   always_comb begin
      if (pick == OWN_DAT) begin
         sel_addr  = dat_addr;
         sel_be    = dat_be;
         sel_wr    = dat_wr;
         sel_wdata = dat_wdata;
      end else begin
         sel_addr  = fch_addr;
         sel_be    = fch_be;
         sel_wr    = fch_wr;
         sel_wdata = fch_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         addr_q  <= '0;
         be_q    <= '0;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else if (load) begin
         addr_q  <= sel_addr;
         be_q    <= sel_be;
         wr_q    <= sel_wr;
         wdata_q <= sel_wdata;
      end
   end

   assign rd_end = finish & ~wr_q;

   for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
      logic lane_take;
      if (LANE_MASKED) begin : g_masked
         assign lane_take = rd_end & be_q[ln];
      end else begin : g_full
         assign lane_take = rd_end;
      end
      always_ff @(posedge clk) begin
         if (rst)
            rdat_q[8*ln +: 8] <= '0;
         else if (lane_take)
            rdat_q[8*ln +: 8] <= bus_din[8*ln +: 8];
      end
   end

   generate
      if (IDLE_ADDR_ZERO) begin : g_addr_zero
         assign bus_addr = busy ? addr_q : '0;
      end else begin : g_addr_hold
         assign bus_addr = addr_q;
      end
   endgenerate

   assign bus_be   = busy ? be_q : '0;
   assign bus_wr   = busy & wr_q;
   assign bus_doe  = busy & wr_q;
   assign bus_dout = wdata_q;
   assign rd_data  = rdat_q;

endmodule

// File: rtl/bus_prio_arb.sv
module bus_prio_arb
   import bpa_pkg::*;
#(
   parameter int unsigned ADDR_W         = 32,
   parameter int unsigned DATA_W         = 32,
   parameter bit          DATA_FIRST     = 1'b1,
   parameter bit          IDLE_ADDR_ZERO = 1'b0,
   parameter bit          LANE_MASKED    = 1'b0,
   localparam int unsigned BE_W          = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fch_req,
   input  logic [ADDR_W-1:0] fch_addr,
   input  logic [BE_W-1:0]   fch_be,
   input  logic              fch_wr,
   input  logic [DATA_W-1:0] fch_wdata,
   output logic              fch_gnt,
   output logic              fch_done,
   input  logic              dat_req,
   input  logic [ADDR_W-1:0] dat_addr,
   input  logic [BE_W-1:0]   dat_be,
   input  logic              dat_wr,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic              dat_gnt,
   output logic              dat_done,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [BE_W-1:0]   bus_be,
   output logic              bus_wr,
   output logic              bus_stb,
   input  logic              bus_rdy,
   input  logic [DATA_W-1:0] bus_din,
   output logic [DATA_W-1:0] bus_dout,
   output logic              bus_doe
);

   generate
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data_w
         $error("bus_prio_arb: DATA_W must be a positive multiple of 8");
      end
      if (ADDR_W < 2 || ADDR_W > 64) begin : g_bad_addr_w
         $error("bus_prio_arb: ADDR_W must lie in 2..64");
      end
      if (bpa_lanes(DATA_W) != BE_W) begin : g_bad_lanes
         $error("bus_prio_arb: lane count mismatch");
      end
   endgenerate

   logic       busy;
   logic       start;
   logic       finish;
   bpa_owner_e pick;
   bpa_owner_e owner;

   bpa_pick #(
      .DATA_FIRST(DATA_FIRST)
   ) i_pick (
      .idle    (~busy),
      .fch_req (fch_req),
      .dat_req (dat_req),
      .start   (start),
      .pick    (pick)
   );

   bpa_seq i_seq (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .pick     (pick),
      .rdy      (bus_rdy),
      .busy     (busy),
      .owner    (owner),
      .finish   (finish),
      .fch_done (fch_done),
      .dat_done (dat_done)
   );

   bpa_hold #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .IDLE_ADDR_ZERO (IDLE_ADDR_ZERO),
      .LANE_MASKED    (LANE_MASKED)
   ) i_hold (
      .clk       (clk),
      .rst       (rst),
      .load      (start),
      .pick      (pick),
      .busy      (busy),
      .finish    (finish),
      .fch_addr  (fch_addr),
      .fch_be    (fch_be),
      .fch_wr    (fch_wr),
      .fch_wdata (fch_wdata),
      .dat_addr  (dat_addr),
      .dat_be    (dat_be),
      .dat_wr    (dat_wr),
      .dat_wdata (dat_wdata),
      .bus_din   (bus_din),
      .bus_addr  (bus_addr),
      .bus_be    (bus_be),
      .bus_wr    (bus_wr),
      .bus_dout  (bus_dout),
      .bus_doe   (bus_doe),
      .rd_data   (rd_data)
   );

   assign bus_stb = busy;
   assign fch_gnt = busy & (owner == OWN_FCH);
   assign dat_gnt = busy & (owner == OWN_DAT);

endmodule

// File: rtl/bpa_chk.sv
module bpa_chk #(
   parameter int unsigned AW         = 32,
   parameter int unsigned BW         = 4,
   parameter bit          DATA_FIRST = 1'b1
) (
   input logic          clk,
   input logic          rst,
   input logic          fch_req,
   input logic          dat_req,
   input logic          fch_gnt,
   input logic          dat_gnt,
   input logic          fch_done,
   input logic          dat_done,
   input logic          bus_stb,
   input logic          bus_rdy,
   input logic          bus_wr,
   input logic          bus_doe,
   input logic [AW-1:0] bus_addr,
   input logic [BW-1:0] bus_be
);

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
      !(fch_gnt && dat_gnt)); // R10

   AST_GRANT_NEEDS_STB: assert property (@(posedge clk) disable iff (rst)
      (fch_gnt || dat_gnt) |-> bus_stb); // R10

   AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (rst)
      (bus_stb && !bus_rdy) |=> (bus_stb && $stable(bus_addr) && $stable(bus_be)
                                  && $stable(bus_wr) && $stable(fch_gnt))); // R4

   AST_END_ON_RDY: assert property (@(posedge clk) disable iff (rst)
      (bus_stb && bus_rdy) |=> !bus_stb); // R6

   AST_DOE_WRITE: assert property (@(posedge clk) disable iff (rst)
      bus_doe |-> (bus_stb && bus_wr)); // R7

   AST_DONE_AFTER_RDY: assert property (@(posedge clk) disable iff (rst)
      (fch_done || dat_done) |-> $past(bus_stb && bus_rdy)); // R9

   AST_DONE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
      (fch_done || dat_done) |=> !(fch_done || dat_done)); // R9

   AST_IDLE_RDY_IGNORED: assert property (@(posedge clk) disable iff (rst)
      !bus_stb |=> !(fch_done || dat_done)); // R12

   AST_FETCH_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
      (!bus_stb && fch_req && !dat_req) |=> fch_gnt); // R3

   generate
      if (DATA_FIRST) begin : g_prio
         AST_DATA_FIRST: assert property (@(posedge clk) disable iff (rst)
            (!bus_stb && dat_req) |=> dat_gnt); // R2
      end
   endgenerate

endmodule

bind bus_prio_arb bpa_chk #(
   .AW         (ADDR_W),
   .BW         (BE_W),
   .DATA_FIRST (DATA_FIRST)
) i_bpa_chk (
   .clk      (clk),
   .rst      (rst),
   .fch_req  (fch_req),
   .dat_req  (dat_req),
   .fch_gnt  (fch_gnt),
   .dat_gnt  (dat_gnt),
   .fch_done (fch_done),
   .dat_done (dat_done),
   .bus_stb  (bus_stb),
   .bus_rdy  (bus_rdy),
   .bus_wr   (bus_wr),
   .bus_doe  (bus_doe),
   .bus_addr (bus_addr),
   .bus_be   (bus_be)
);

// File: tb/test_bus_prio_arb.sv
`timescale 1ns/1ps
module test_bus_prio_arb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        fch_req = 1'b0, fch_wr = 1'b0;
   logic [31:0] fch_addr = '0, fch_wdata = '0;
   logic [3:0]  fch_be = '0;
   logic        dat_req = 1'b0, dat_wr = 1'b0;
   logic [31:0] dat_addr = '0, dat_wdata = '0;
   logic [3:0]  dat_be = '0;
   logic        bus_rdy = 1'b0;
   logic [31:0] bus_din = '0;
   logic        fch_gnt, fch_done, dat_gnt, dat_done;
   logic [31:0] rd_data, bus_addr, bus_dout;
   logic [3:0]  bus_be;
   logic        bus_wr, bus_stb, bus_doe;

   int total = 0;
   int bad   = 0;
   int cycles = 0;

   always #2 clk = ~clk;

   bus_prio_arb i_bus_prio_arb (
      .clk(clk), .rst(rst),
      .fch_req(fch_req), .fch_addr(fch_addr), .fch_be(fch_be), .fch_wr(fch_wr),
      .fch_wdata(fch_wdata), .fch_gnt(fch_gnt), .fch_done(fch_done),
      .dat_req(dat_req), .dat_addr(dat_addr), .dat_be(dat_be), .dat_wr(dat_wr),
      .dat_wdata(dat_wdata), .dat_gnt(dat_gnt), .dat_done(dat_done),
      .rd_data(rd_data), .bus_addr(bus_addr), .bus_be(bus_be), .bus_wr(bus_wr),
      .bus_stb(bus_stb), .bus_rdy(bus_rdy), .bus_din(bus_din),
      .bus_dout(bus_dout), .bus_doe(bus_doe)
   );

   // behavioural reference: who owns the bus, what it latched, what came back
   int          m_busy = 0;
   int          m_own  = 0;   // 0 fetcher, 1 execution client
   logic [31:0] m_addr = '0, m_wd = '0, m_rd = '0;
   logic [3:0]  m_be = '0;
   int          m_wr = 0;
   int          m_fdone = 0, m_ddone = 0;

   always @(posedge clk) begin
      cycles++;
      if (rst) begin
         m_busy = 0; m_own = 0; m_fdone = 0; m_ddone = 0; m_rd = '0;
         m_addr = '0; m_be = '0; m_wr = 0; m_wd = '0;
      end else begin
         m_fdone = 0; m_ddone = 0;
         if (m_busy != 0) begin
            if (bus_rdy) begin
               m_busy = 0;
               if (m_wr == 0) m_rd = bus_din;
               if (m_own == 0) m_fdone = 1; else m_ddone = 1;
            end
         end else if (dat_req) begin
            m_busy = 1; m_own = 1;
            m_addr = dat_addr; m_be = dat_be; m_wr = int'(dat_wr); m_wd = dat_wdata;
         end else if (fch_req) begin
            m_busy = 1; m_own = 0;
            m_addr = fch_addr; m_be = fch_be; m_wr = int'(fch_wr); m_wd = fch_wdata;
         end
      end
      if (cycles > 20000) begin
         bad++;
         $display("FAIL watchdog (all requirements) actual=%0d cycles expected=under 20000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_model();
      logic eb;
      logic ew;
      eb = (m_busy != 0);
      ew = eb && (m_wr != 0);
      chk("R6 bus_stb vs model", {31'd0, bus_stb}, {31'd0, eb});
      chk("R7 bus_doe vs model", {31'd0, bus_doe}, {31'd0, ew});
      chk("R7 bus_wr vs model", {31'd0, bus_wr}, {31'd0, ew});
      chk("R7 bus_be vs model", {28'd0, bus_be}, eb ? {28'd0, m_be} : 32'd0);
      chk("R10 fch_gnt vs model", {31'd0, fch_gnt}, {31'd0, eb && m_own == 0});
      chk("R10 dat_gnt vs model", {31'd0, dat_gnt}, {31'd0, eb && m_own == 1});
      chk("R9 fch_done vs model", {31'd0, fch_done}, {31'd0, m_fdone != 0});
      chk("R9 dat_done vs model", {31'd0, dat_done}, {31'd0, m_ddone != 0});
      chk("R8 rd_data vs model", rd_data, m_rd);
      if (eb) chk("R5 bus_addr vs model", bus_addr, m_addr);
      if (ew) chk("R5 bus_dout vs model", bus_dout, m_wd);
   endtask

   task automatic tick();
      @(negedge clk);
      compare_model();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   initial begin
      ticks(3);
      chk("R1 stb in reset", {31'd0, bus_stb}, 32'd0);
      chk("R1 be in reset", {28'd0, bus_be}, 32'd0);
      rst = 1'b0;
      tick();
      chk("R1 stb after reset", {31'd0, bus_stb}, 32'd0);
      chk("R1 rd_data after reset", rd_data, 32'd0);
      chk("R1 done after reset", {30'd0, fch_done, dat_done}, 32'd0);

      // fetch read with two wait states
      fch_req = 1'b1; fch_addr = 32'h0000_1000; fch_be = 4'hF; fch_wr = 1'b0;
      tick();
      chk("R3 fetch granted alone", {31'd0, fch_gnt}, 32'd1);
      chk("R5 fetch address on bus", bus_addr, 32'h0000_1000);
      fch_addr = 32'hDEAD_0000;
      ticks(2);
      chk("R4 address held over wait", bus_addr, 32'h0000_1000);
      bus_rdy = 1'b1; bus_din = 32'hA5A5_1234;
      tick();
      chk("R6 stb low after ready", {31'd0, bus_stb}, 32'd0);
      chk("R9 fetch done pulse", {31'd0, fch_done}, 32'd1);
      chk("R8 read data captured", rd_data, 32'hA5A5_1234);
      fch_req = 1'b0; bus_rdy = 1'b0;
      tick();
      chk("R9 done lasts one clock", {31'd0, fch_done}, 32'd0);

      // execution write, ready at once
      dat_req = 1'b1; dat_addr = 32'h0000_2004; dat_be = 4'b0011;
      dat_wr = 1'b1; dat_wdata = 32'h1122_3344;
      tick();
      chk("R7 doe during write", {31'd0, bus_doe}, 32'd1);
      chk("R5 write data on bus", bus_dout, 32'h1122_3344);
      bus_rdy = 1'b1; bus_din = 32'hFFFF_FFFF;
      tick();
      chk("R8 write leaves rd_data", rd_data, 32'hA5A5_1234);
      chk("R9 done only to owner", {30'd0, fch_done, dat_done}, 32'd1);
      dat_req = 1'b0; bus_rdy = 1'b0;
      tick();

      // both request together: execution client wins, fetch follows after one idle cycle
      fch_req = 1'b1; fch_addr = 32'h0000_3000; fch_wr = 1'b0; fch_be = 4'hF;
      dat_req = 1'b1; dat_addr = 32'h0000_4000; dat_wr = 1'b0; dat_be = 4'hC;
      tick();
      chk("R2 data beats fetch", {30'd0, fch_gnt, dat_gnt}, 32'd1);
      tick();
      bus_rdy = 1'b1; bus_din = 32'h0BAD_F00D;
      tick();
      chk("R11 idle slot after cycle", {31'd0, bus_stb}, 32'd0);
      dat_req = 1'b0; bus_rdy = 1'b0;
      tick();
      chk("R3 waiting fetch served", {31'd0, fch_gnt}, 32'd1);
      chk("R5 fetch address after wait", bus_addr, 32'h0000_3000);

      // execution client asks mid-fetch: no pre-emption
      dat_req = 1'b1; dat_addr = 32'h0000_5000; dat_wr = 1'b1; dat_wdata = 32'hCAFE_0001;
      ticks(3);
      chk("R4 fetch keeps bus", {30'd0, fch_gnt, dat_gnt}, 32'd2);
      chk("R4 fetch address kept", bus_addr, 32'h0000_3000);
      bus_rdy = 1'b1; bus_din = 32'h7777_8888;
      tick();
      chk("R8 fetch read data", rd_data, 32'h7777_8888);
      bus_rdy = 1'b0;
      tick();
      chk("R2 data wins with fetch still waiting", {30'd0, fch_gnt, dat_gnt}, 32'd1);
      bus_rdy = 1'b1;
      tick();
      dat_req = 1'b0; fch_req = 1'b0; bus_rdy = 1'b0;
      tick();

      // stray ready while idle
      bus_rdy = 1'b1; bus_din = 32'h1357_9BDF;
      ticks(3);
      chk("R12 no done from idle ready", {30'd0, fch_done, dat_done}, 32'd0);
      chk("R12 rd_data untouched", rd_data, 32'h7777_8888);
      bus_rdy = 1'b0;

      // back-to-back execution reads with request held and zero wait
      dat_req = 1'b1; dat_wr = 1'b0; dat_addr = 32'h0000_6000; dat_be = 4'hF;
      tick();
      bus_rdy = 1'b1;
      for (int k = 0; k < 4; k++) begin
         bus_din = 32'h6000_0000 + k;
         dat_addr = 32'h0000_6000 + 32'(k) * 4;
         tick();
         chk("R11 exactly one idle between cycles", {31'd0, bus_stb}, 32'd0);
         tick();
         chk("R11 next cycle restarts", {31'd0, bus_stb}, 32'd1);
      end
      dat_req = 1'b0;
      tick();
      bus_rdy = 1'b0;
      ticks(2);
      chk("R8 last back-to-back read", rd_data, 32'h6000_0003);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule